// File: doc/BRIEF.md
# Operating-Mode and Clock-Gating Controller

This block decides how a small microcontroller spends its clocks. While the CPU runs, a 3-bit clock-select code chooses the system clock. Codes 0 to 6 take the high-speed clock divided by a power of two. Code 7 takes a low-speed sub-clock instead. A HALT request from the CPU parks the controller in one of four stopped modes. Two idle-enable bits pick the mode, and each mode keeps a different set of oscillators alive. A wake-up event returns the controller to a running mode.

The block runs on a single clock, which stands for the high-speed oscillator. The system clock leaves the block as `sysTick`, a one-cycle clock-enable pulse at each system-clock edge. The two sub-clock sources arrive as synchronous levels, and a rising edge of the selected one is a sub-clock edge. The controller adopts a new select code only at a system-clock boundary, so a change never makes a short period.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is FAST (code 0) and `cpuClkEn` is 1. The active select code is 0, so `sysTick` pulses on every cycle.
- R2: While running with active code k in 0..6, the mode is FAST (0). `sysTick` pulses once every 2^k cycles.
- R3: While running with active code 7, the mode is SLOW (1). `sysTick` pulses in the cycle where the selected sub-clock level shows a rising edge, meaning it is 1 now and was 0 in the previous cycle. The level is `lircLvl` when `subSrcSel`=0 and `lxtLvl` when `subSrcSel`=1.
- R4: A new `clkSel` value becomes active only at a system-clock boundary, in the cycle after a boundary. A boundary is the last cycle of a divided period, or a sub-clock edge while code 7 is active. Between boundaries the old timing continues.
- R5: `haltReq` while running drops `cpuClkEn` in the next cycle. The mode becomes SLEEP (5), IDLE0 (2), IDLE1 (3) or IDLE2 (4) for {hsIdleEn,subIdleEn} = 00, 01, 11, 10. `haltReq` while stopped has no effect.
- R6: In SLEEP the high-speed enable, the sub-clock enable and `sysTick` are all 0.
- R7: In IDLE0 `hsClkEn`=0 and `subClkEn`=1. `sysTick` continues only if the active code is 7.
- R8: In IDLE1 `hsClkEn`=1 and `subClkEn`=1. `sysTick` continues whatever the active code.
- R9: In IDLE2 `hsClkEn`=1 and `subClkEn`=0. `sysTick` continues only if the active code is 0..6.
- R10: While running, `subClkEn`=1. `hsClkEn` is 1 in FAST and follows `hsOscOn` in SLOW.
- R11: `lircClkEn` is 1 in every mode.
- R12: `wakeEvt` in a stopped mode brings back `cpuClkEn` in the next cycle. The mode then follows the active code, FAST or SLOW. `wakeEvt` while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed clock |
| rstN | input | 1 | Asynchronous active-low reset |
| haltReq | input | 1 | HALT request from the CPU |
| wakeEvt | input | 1 | Wake-up event |
| hsIdleEn | input | 1 | Keep the high-speed clock while stopped |
| subIdleEn | input | 1 | Keep the sub-clock while stopped |
| clkSel | input | SEL_W | Requested clock-select code |
| subSrcSel | input | 1 | Sub-clock source: 0 internal, 1 crystal |
| hsOscOn | input | 1 | High-speed oscillator enable for SLOW mode |
| lircLvl | input | 1 | Low-speed internal oscillator level |
| lxtLvl | input | 1 | Low-speed crystal level |
| mode | output | 3 | Current mode code |
| cpuClkEn | output | 1 | CPU clock enable |
| hsClkEn | output | 1 | High-speed clock enable |
| subClkEn | output | 1 | Sub-clock enable |
| lircClkEn | output | 1 | Low-speed internal clock enable |
| sysTick | output | 1 | System clock-enable pulse |

## Verification
Directed runs first step through every divide code. They then change the code in the middle of a long period, which tells a boundary-aligned switch from an immediate one. Each of the four idle-enable combinations is halted with a FAST code and with code 7, so the eight gating outcomes differ. Both sub-clock sources drive SLOW mode at different toggle rates, which shows which source was picked. A long random run then mixes HALT, wake, stray requests and code changes while each mode holds.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    MODE_FAST  = 3'd0,
    MODE_SLOW  = 3'd1,
    MODE_IDLE0 = 3'd2,
    MODE_IDLE1 = 3'd3,
    MODE_IDLE2 = 3'd4,
    MODE_SLEEP = 3'd5
  } pmcMode_e;

  typedef enum logic [2:0] {
    ST_RUN, ST_IDLE0, ST_IDLE1, ST_IDLE2, ST_SLEEP
  } pmcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hsOn;
    logic subOn;
    logic sysOn;
  } pmcStrobe_t;
endpackage

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltReq,
  input  logic       wakeEvt,
  input  logic       hsIdleEn,
  input  logic       subIdleEn,
  input  logic       hsOscOn,
  input  logic       slowActive,
  output logic [2:0] mode,
  output logic       cpuClkEn,
  output logic       hsClkEn,
  output logic       subClkEn,
  output logic       lircClkEn,
  output pmcStrobe_t strobe
);
  pmcState_e state, haltTarget;

  always_comb begin
    unique case ({hsIdleEn, subIdleEn})
      2'b00:   haltTarget = ST_SLEEP;
      2'b01:   haltTarget = ST_IDLE0;
      2'b11:   haltTarget = ST_IDLE1;
      default: haltTarget = ST_IDLE2;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
    end else if (state == ST_RUN) begin
      if (haltReq) state <= haltTarget;
    end else if (wakeEvt) begin
      state <= ST_RUN;
    end
  end

  always_comb begin
    pmcMode_e modeE;
    cpuClkEn     = 1'b0;
    lircClkEn    = 1'b1;
    strobe.hsOn  = 1'b0;
    strobe.subOn = 1'b0;
    strobe.sysOn = 1'b0;
    modeE        = MODE_SLEEP;
    case (state)
      ST_RUN: begin
        cpuClkEn     = 1'b1;
        strobe.hsOn  = slowActive ? hsOscOn : 1'b1;
        strobe.subOn = 1'b1;
        strobe.sysOn = 1'b1;
        modeE        = slowActive ? MODE_SLOW : MODE_FAST;
      end
      ST_IDLE0: begin
        strobe.subOn = 1'b1;
        strobe.sysOn = slowActive;
        modeE        = MODE_IDLE0;
      end
      ST_IDLE1: begin
        strobe.hsOn  = 1'b1;
        strobe.subOn = 1'b1;
        strobe.sysOn = 1'b1;
        modeE        = MODE_IDLE1;
      end
      ST_IDLE2: begin
        strobe.hsOn  = 1'b1;
        strobe.sysOn = !slowActive;
        modeE        = MODE_IDLE2;
      end
      default: modeE = MODE_SLEEP;
    endcase
    mode     = modeE;
    hsClkEn  = strobe.hsOn;
    subClkEn = strobe.subOn;
  end
endmodule

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  pmcStrobe_t       strobe,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             subSrcSel,
  input  logic             lircLvl,
  input  logic             lxtLvl,
  output logic             slowActive,
  output logic             sysTick
);
  localparam int NUM_CODES = 1 << SEL_W;
  localparam int NUM_DIV   = NUM_CODES - 1;
  localparam int CNT_W     = (NUM_DIV > 1) ? NUM_DIV - 1 : 1;
  localparam logic [SEL_W-1:0] SLOW_CODE = {SEL_W{1'b1}};

  logic [CNT_W-1:0] limTab [NUM_CODES];
  logic [SEL_W-1:0] activeSel;
  logic [CNT_W-1:0] divCnt;
  logic             subPrev, subLvl, subEdge, boundary;

  // terminal count for each divide code; the sub-clock code has none
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_lim
    if (g < NUM_DIV) begin : g_div
      assign limTab[g] = CNT_W'((1 << g) - 1);
    end else begin : g_sub
      assign limTab[g] = '0;
    end
  end

  assign slowActive = (activeSel == SLOW_CODE);
  assign subLvl     = subSrcSel ? lxtLvl : lircLvl;
  assign subEdge    = strobe.subOn & subLvl & ~subPrev;
  assign boundary   = slowActive ? subEdge
                                 : (strobe.hsOn && divCnt == limTab[activeSel]);
  assign sysTick    = strobe.sysOn & boundary;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeSel <= '0;
      divCnt    <= '0;
      subPrev   <= 1'b0;
    end else begin
      subPrev <= subLvl;
      if (boundary) begin
        activeSel <= clkSel;
        divCnt    <= '0;
      end else if (!slowActive && strobe.hsOn) begin
        divCnt <= divCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltReq,
  input  logic             wakeEvt,
  input  logic             hsIdleEn,
  input  logic             subIdleEn,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             subSrcSel,
  input  logic             hsOscOn,
  input  logic             lircLvl,
  input  logic             lxtLvl,
  output logic [2:0]       mode,
  output logic             cpuClkEn,
  output logic             hsClkEn,
  output logic             subClkEn,
  output logic             lircClkEn,
  output logic             sysTick
);
  pmcStrobe_t strobe;
  logic       slowActive;

  pmc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .wakeEvt(wakeEvt),
    .hsIdleEn(hsIdleEn), .subIdleEn(subIdleEn), .hsOscOn(hsOscOn),
    .slowActive(slowActive), .mode(mode), .cpuClkEn(cpuClkEn),
    .hsClkEn(hsClkEn), .subClkEn(subClkEn), .lircClkEn(lircClkEn),
    .strobe(strobe)
  );

  pmc_datapath #(.SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .clkSel(clkSel),
    .subSrcSel(subSrcSel), .lircLvl(lircLvl), .lxtLvl(lxtLvl),
    .slowActive(slowActive), .sysTick(sysTick)
  );
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       haltReq,
  input logic       wakeEvt,
  input logic [2:0] mode,
  input logic       cpuClkEn,
  input logic       hsClkEn,
  input logic       subClkEn,
  input logic       lircClkEn,
  input logic       sysTick
);
  assert_lirc_on_R11: assert property (@(posedge clk) disable iff (!rstN)
    lircClkEn);

  assert_halt_stops_R5: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn && haltReq |=> !cpuClkEn);

  assert_wake_resumes_R12: assert property (@(posedge clk) disable iff (!rstN)
    !cpuClkEn && wakeEvt |=> cpuClkEn);

  assert_sleep_dark_R6: assert property (@(posedge clk) disable iff (!rstN)
    mode == 3'd5 |-> !hsClkEn && !subClkEn && !sysTick);

  assert_idle0_gates_R7: assert property (@(posedge clk) disable iff (!rstN)
    mode == 3'd2 |-> !hsClkEn && subClkEn);

  assert_idle1_gates_R8: assert property (@(posedge clk) disable iff (!rstN)
    mode == 3'd3 |-> hsClkEn && subClkEn);

  assert_idle2_gates_R9: assert property (@(posedge clk) disable iff (!rstN)
    mode == 3'd4 |-> hsClkEn && !subClkEn);

  assert_fast_hs_on_R10: assert property (@(posedge clk) disable iff (!rstN)
    mode == 3'd0 |-> hsClkEn && subClkEn);
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
  .clk(clk), .rstN(rstN), .haltReq(haltReq), .wakeEvt(wakeEvt),
  .mode(mode), .cpuClkEn(cpuClkEn), .hsClkEn(hsClkEn),
  .subClkEn(subClkEn), .lircClkEn(lircClkEn), .sysTick(sysTick)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       haltReq = 0, wakeEvt = 0, hsIdleEn = 0, subIdleEn = 0;
  logic [2:0] clkSel = 0;
  logic       subSrcSel = 0, hsOscOn = 1, lircLvl = 0, lxtLvl = 0;
  logic [2:0] mode;
  logic       cpuClkEn, hsClkEn, subClkEn, lircClkEn, sysTick;

  int compared = 0, mismatched = 0, cycles = 0;
  int lircCnt = 0, lxtCnt = 0;
  int lircHalf = 3, lxtHalf = 5;
  bit done = 0;

  // bench reference model: 0 run, 1 idle0, 2 idle1, 3 idle2, 4 sleep
  int mState, mSel, mCnt;
  bit mPrev;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .wakeEvt(wakeEvt),
    .hsIdleEn(hsIdleEn), .subIdleEn(subIdleEn), .clkSel(clkSel),
    .subSrcSel(subSrcSel), .hsOscOn(hsOscOn), .lircLvl(lircLvl),
    .lxtLvl(lxtLvl), .mode(mode), .cpuClkEn(cpuClkEn), .hsClkEn(hsClkEn),
    .subClkEn(subClkEn), .lircClkEn(lircClkEn), .sysTick(sysTick)
  );

  function automatic bit eSlow(); return mSel == 7; endfunction
  function automatic bit eHs();
    case (mState)
      0: return eSlow() ? hsOscOn : 1'b1;
      2, 3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
  function automatic bit eSub(); return mState <= 2; endfunction
  function automatic bit eSysOn();
    return mState == 0 || mState == 2 || (mState == 1 && eSlow())
        || (mState == 3 && !eSlow());
  endfunction
  function automatic bit eBoundary();
    bit lvl = subSrcSel ? lxtLvl : lircLvl;
    if (eSlow()) return eSub() && lvl && !mPrev;
    return eHs() && (mCnt == (1 << mSel) - 1);
  endfunction
  function automatic int eMode();
    if (mState == 0) return eSlow() ? 1 : 0;
    return mState + 1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState <= 0; mSel <= 0; mCnt <= 0; mPrev <= 0;
    end else begin
      mPrev <= subSrcSel ? lxtLvl : lircLvl;
      if (eBoundary()) begin mSel <= int'(clkSel); mCnt <= 0; end
      else if (!eSlow() && eHs()) mCnt <= mCnt + 1;
      if (mState == 0) begin
        if (haltReq)
          mState <= !hsIdleEn ? (subIdleEn ? 1 : 4) : (subIdleEn ? 2 : 3);
      end else if (wakeEvt) mState <= 0;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic string stateTag();
    case (mState)
      1: return "R7";
      2: return "R8";
      3: return "R9";
      4: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic compareAll();
    string tickTag;
    if (mState != 0) tickTag = stateTag();
    else if (int'(clkSel) != mSel) tickTag = "R4";
    else tickTag = eSlow() ? "R3" : "R2";
    check(tickTag, "sysTick", int'(sysTick), int'(eSysOn() && eBoundary()));
    check(mState != 0 ? "R5" : "R12", "mode", int'(mode), eMode());
    check(mState != 0 ? "R5" : "R12", "cpuClkEn", int'(cpuClkEn), int'(mState == 0));
    check(stateTag(), "hsClkEn", int'(hsClkEn), int'(eHs()));
    check(stateTag(), "subClkEn", int'(subClkEn), int'(eSub()));
    check("R11", "lircClkEn", int'(lircClkEn), 1);
  endtask

  // one cycle: advance sub-clock levels, compare just after the negedge
  task automatic step();
    lircCnt++; if (lircCnt >= lircHalf) begin lircCnt = 0; lircLvl = ~lircLvl; end
    lxtCnt++;  if (lxtCnt >= lxtHalf)   begin lxtCnt = 0;  lxtLvl = ~lxtLvl;   end
    #1;
    compareAll();
    @(negedge clk);
  endtask

  task automatic runN(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic haltWake(bit hsI, bit subI, logic [2:0] sel, int stay);
    clkSel = sel;
    runN(140);
    hsIdleEn = hsI; subIdleEn = subI;
    haltReq = 1; step(); haltReq = 0;
    haltReq = 1; step(); haltReq = 0;   // stray HALT while stopped (R5)
    runN(stay);
    wakeEvt = 1; step(); wakeEvt = 0;
    wakeEvt = 1; step(); wakeEvt = 0;   // stray wake while running (R12)
    runN(4);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check("R1", "reset mode", int'(mode), 0);
    check("R1", "reset cpuClkEn", int'(cpuClkEn), 1);
    check("R1", "reset sysTick", int'(sysTick), 1);
    @(negedge clk);
    runN(4);
    // every divide code (R2), then mid-period switch (R4)
    for (int k = 0; k < 7; k++) begin clkSel = 3'(k); runN(2 * (1 << k) + 2); end
    clkSel = 3'd6; runN(70);
    clkSel = 3'd1; runN(20);
    clkSel = 3'd5; runN(40);
    clkSel = 3'd0; runN(10);
    // sub-clock sources (R3), hsOscOn in SLOW (R10)
    clkSel = 3'd7; runN(30);
    subSrcSel = 1; runN(40);
    hsOscOn = 0; runN(20); hsOscOn = 1;
    subSrcSel = 0; clkSel = 3'd2; runN(20);
    // all idle combinations with FAST and SLOW codes (R5..R9, R12)
    for (int c = 0; c < 4; c++) begin
      haltWake(c[1], c[0], 3'd2, 30);
      haltWake(c[1], c[0], 3'd7, 30);
    end
    // constrained random
    for (int i = 0; i < 6000; i++) begin
      haltReq = ($urandom % 25) == 0;
      wakeEvt = ($urandom % 20) == 0;
      hsIdleEn = $urandom % 2; subIdleEn = $urandom % 2;
      if ($urandom % 40 == 0) clkSel = 3'($urandom % 8);
      if ($urandom % 60 == 0) subSrcSel = ~subSrcSel;
      if ($urandom % 30 == 0) hsOscOn = ~hsOscOn;
      if ($urandom % 200 == 0) begin lircHalf = 1 + $urandom % 4; lxtHalf = 1 + $urandom % 6; end
      step();
    end
    done = 1;
  end

  initial begin
    while (!done && cycles < WATCHDOG) begin @(posedge clk); cycles++; end
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule